// File: doc/BRIEF.md
# Transfer Length Command Encoder

The block converts a requested byte count and a template command word into the shortest run of command entries that a downstream flash sequencer can execute. A count below 255 fits in one literal entry. A larger count is split. Each set bit at position 8 or higher becomes a power-of-two entry that carries the bit number. These entries come out lowest bit first. A literal entry for the low byte follows them, but only when that byte is nonzero.

Each entry leaves on a valid/ready handshake, one entry per accepted cycle. All template bits outside the immediate field and the exponent flag are copied into every data entry. Some reads run with the processor moving the data itself. For those the requester sets a terminator flag, and an all-zero entry is appended after the data entries. A one-cycle done pulse marks the acceptance of the final entry.

Top module: `len_cmd_encoder`

## Requirements
- R1: A length below 255 gives exactly one entry. That entry has bit 9 (exponent flag) at 0 and bits [7:0] equal to the length.
- R2: A length of 255 or more gives one entry for each set length bit k with k >= 8. Each such entry has bit 9 at 1 and bits [7:0] equal to k.
- R3: Exponent entries leave in ascending order of k.
- R4: When the split path is taken, a literal entry (bit 9 at 0, bits [7:0] equal to length[7:0]) follows the exponent entries if length[7:0] is nonzero. No literal entry is produced if length[7:0] is zero.
- R5: A length of exactly 255 gives only one literal entry, with immediate 255.
- R6: Every data entry carries template bits [19:10] and bit 8 unchanged.
- R7: With the terminator flag set, an all-zero entry is emitted after the last data entry.
- R8: While valid is high and ready is low, valid stays high and the entry value does not change.
- R9: busy is high from the cycle after an accepted start until the final entry is accepted. In the cycle after that final handshake, done is high for exactly one cycle and busy is low.
- R10: A start pulse received while busy does not change the entry stream of the running command, and it does not begin a second command.
- R11: After reset, valid, busy and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin encoding; accepted only while idle |
| len_i | input | 25 | Requested byte count, up to 2^24 |
| tmpl_i | input | 20 | Template command word |
| term_i | input | 1 | Append an all-zero terminator entry |
| ent_valid_o | output | 1 | Entry on ent_data_o is valid |
| ent_ready_i | input | 1 | Consumer accepts the entry this cycle |
| ent_data_o | output | 20 | Command entry |
| busy_o | output | 1 | A command is being emitted |
| done_o | output | 1 | One-cycle pulse after the final entry is accepted |

## Verification
The remaining-bit mask and the stage register decide everything the consumer sees. A bit left uncleared shows up as a repeated exponent entry on the very next accepted handshake. A stage that moves on wrongly shows up as a missing or extra literal or terminator entry, and it also shifts the done pulse by one or more cycles. Randomised ready stalls reveal any change in the entry value during a stall one cycle after it happens. A start accepted while busy would corrupt the expected stream or raise valid after done.

// File: rtl/lce_pkg.sv
package lce_pkg;

    localparam int ENT_W      = 20;
    localparam int IMM_W      = 8;
    localparam int EXP_POS    = 9;
    localparam int SPLIT_BASE = 8;
    localparam int LIT_LIMIT  = 255;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXP  = 2'd1,
        ST_LIT  = 2'd2,
        ST_TERM = 2'd3
    } lce_stage_e;

    typedef struct packed {
        logic [ENT_W-1:EXP_POS+1] upper;
        logic                     exp_f;
        logic [EXP_POS-1:IMM_W]   mid;
        logic [IMM_W-1:0]         imm;
    } lce_entry_t;

    function automatic lce_entry_t make_entry(
        input logic [ENT_W-1:0] tmpl,
        input logic             exp_f,
        input logic [IMM_W-1:0] imm
    );
        lce_entry_t e;
        e       = lce_entry_t'(tmpl);
        e.exp_f = exp_f;
        e.imm   = imm;
        return e;
    endfunction

endpackage

// File: rtl/lce_low_pick.sv
module lce_low_pick #(
    parameter int W     = 17,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     mask_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    // Lowest set bit wins: scan from the top so the last hit is the lowest.
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                idx_o = IDX_W'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lce_ctrl.sv
module lce_ctrl
    import lce_pkg::*;
#(
    parameter int LEN_W = 25,
    localparam int HI_W = LEN_W - SPLIT_BASE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [ENT_W-1:0]    tmpl_i,
    input  logic                term_i,
    input  logic                ready_i,
    output lce_stage_e          stage_o,
    output logic [HI_W-1:0]     hi_o,
    output logic [IMM_W-1:0]    lo_o,
    output logic [ENT_W-1:0]    tmpl_o,
    output logic                done_o
);
    localparam logic [LEN_W-1:0] LIT_LIM = LEN_W'(LIT_LIMIT);

    lce_stage_e         stage_q, stage_n;
    logic [HI_W-1:0]    hi_q, hi_n, hi_rest;
    logic [IMM_W-1:0]   lo_q, lo_n;
    logic [ENT_W-1:0]   tmpl_q, tmpl_n;
    logic               term_q, term_n;
    logic               done_n;

    assign hi_rest = hi_q & (hi_q - HI_W'(1));

    always_comb begin
        stage_n = stage_q;
        hi_n    = hi_q;
        lo_n    = lo_q;
        tmpl_n  = tmpl_q;
        term_n  = term_q;
        done_n  = 1'b0;
        case (stage_q)
            ST_IDLE: begin
                if (start_i) begin
                    tmpl_n = tmpl_i;
                    term_n = term_i;
                    lo_n   = len_i[IMM_W-1:0];
                    if (len_i < LIT_LIM) begin
                        hi_n    = '0;
                        stage_n = ST_LIT;
                    end else begin
                        hi_n    = len_i[LEN_W-1:SPLIT_BASE];
                        stage_n = (len_i[LEN_W-1:SPLIT_BASE] != '0) ? ST_EXP : ST_LIT;
                    end
                end
            end
            ST_EXP: begin
                if (ready_i) begin
                    hi_n = hi_rest;
                    if (hi_rest == '0) begin
                        if (lo_q != '0)  stage_n = ST_LIT;
                        else if (term_q) stage_n = ST_TERM;
                        else begin
                            stage_n = ST_IDLE;
                            done_n  = 1'b1;
                        end
                    end
                end
            end
            ST_LIT: begin
                if (ready_i) begin
                    if (term_q) stage_n = ST_TERM;
                    else begin
                        stage_n = ST_IDLE;
                        done_n  = 1'b1;
                    end
                end
            end
            default: begin
                if (ready_i) begin
                    stage_n = ST_IDLE;
                    done_n  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= ST_IDLE;
            hi_q    <= '0;
            lo_q    <= '0;
            tmpl_q  <= '0;
            term_q  <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            stage_q <= stage_n;
            hi_q    <= hi_n;
            lo_q    <= lo_n;
            tmpl_q  <= tmpl_n;
            term_q  <= term_n;
            done_o  <= done_n;
        end
    end

    assign stage_o = stage_q;
    assign hi_o    = hi_q;
    assign lo_o    = lo_q;
    assign tmpl_o  = tmpl_q;
endmodule

// File: rtl/lce_fmt.sv
module lce_fmt
    import lce_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  lce_stage_e        stage_i,
    input  logic [ENT_W-1:0]  tmpl_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [IMM_W-1:0]  lo_i,
    output logic [ENT_W-1:0]  data_o
);
    logic [IMM_W-1:0] exp_imm;

    assign exp_imm = IMM_W'(idx_i) + IMM_W'(SPLIT_BASE);

    always_comb begin
        case (stage_i)
            ST_EXP:  data_o = make_entry(tmpl_i, 1'b1, exp_imm);
            ST_LIT:  data_o = make_entry(tmpl_i, 1'b0, lo_i);
            default: data_o = '0;
        endcase
    end
endmodule

// File: rtl/len_cmd_encoder.sv
module len_cmd_encoder
    import lce_pkg::*;
#(
    parameter int LEN_W = 25,
    localparam int HI_W  = LEN_W - SPLIT_BASE,
    localparam int IDX_W = (HI_W > 1) ? $clog2(HI_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ENT_W-1:0]  tmpl_i,
    input  logic              term_i,
    output logic              ent_valid_o,
    input  logic              ent_ready_i,
    output logic [ENT_W-1:0]  ent_data_o,
    output logic              busy_o,
    output logic              done_o
);
    lce_stage_e        stage;
    logic [HI_W-1:0]   hi;
    logic [IMM_W-1:0]  lo;
    logic [ENT_W-1:0]  tmpl;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_any;
    logic              ctrl_ready;

    assign ctrl_ready = ent_ready_i;

    lce_ctrl #(.LEN_W(LEN_W)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .len_i   (len_i),
        .tmpl_i  (tmpl_i),
        .term_i  (term_i),
        .ready_i (ctrl_ready),
        .stage_o (stage),
        .hi_o    (hi),
        .lo_o    (lo),
        .tmpl_o  (tmpl),
        .done_o  (done_o)
    );

    lce_low_pick #(.W(HI_W), .IDX_W(IDX_W)) pick_i (
        .mask_i (hi),
        .idx_o  (pick_idx),
        .any_o  (pick_any)
    );

    lce_fmt #(.IDX_W(IDX_W)) fmt_i (
        .stage_i (stage),
        .tmpl_i  (tmpl),
        .idx_i   (pick_idx),
        .lo_i    (lo),
        .data_o  (ent_data_o)
    );

    // The picker's any flag is meaningful only in the exponent stage.
    assign ent_valid_o = (stage != ST_IDLE) && ((stage != ST_EXP) || pick_any);
    assign busy_o      = (stage != ST_IDLE);
endmodule

// File: rtl/len_cmd_encoder_chk.sv
module len_cmd_encoder_chk
    import lce_pkg::*;
#(
    parameter int LEN_W = 25
) (
    input logic             clk,
    input logic             rst,
    input logic             ent_valid_o,
    input logic             ent_ready_i,
    input logic [ENT_W-1:0] ent_data_o,
    input logic             busy_o,
    input logic             done_o
);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        ent_valid_o && !ent_ready_i |=> ent_valid_o && $stable(ent_data_o));

    a_r9_done_after_hs: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(ent_valid_o && ent_ready_i));

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r2_exp_range: assert property (@(posedge clk) disable iff (rst)
        ent_valid_o && ent_data_o[EXP_POS] |->
            (ent_data_o[IMM_W-1:0] >= IMM_W'(SPLIT_BASE)) &&
            (ent_data_o[IMM_W-1:0] < IMM_W'(LEN_W)));

    a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
        $past(ent_valid_o && ent_ready_i && ent_data_o[EXP_POS]) &&
        ent_valid_o && ent_data_o[EXP_POS] |->
            ent_data_o[IMM_W-1:0] > $past(ent_data_o[IMM_W-1:0]));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !ent_valid_o);
endmodule

bind len_cmd_encoder len_cmd_encoder_chk #(.LEN_W(LEN_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ent_valid_o (ent_valid_o),
    .ent_ready_i (ent_ready_i),
    .ent_data_o  (ent_data_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/len_cmd_encoder_tb_top.sv
`timescale 1ns/1ps
module len_cmd_encoder_tb_top;
    localparam int LEN_W = 25;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [LEN_W-1:0]  len_i = '0;
    logic [19:0]       tmpl_i = '0;
    logic              term_i = 1'b0;
    logic              ent_ready_i = 1'b0;
    logic              ent_valid_o;
    logic [19:0]       ent_data_o;
    logic              busy_o;
    logic              done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [19:0] exp_q[$];

    always #2.5 clk = ~clk;

    len_cmd_encoder #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
        .tmpl_i(tmpl_i), .term_i(term_i), .ent_valid_o(ent_valid_o),
        .ent_ready_i(ent_ready_i), .ent_data_o(ent_data_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    // Reference model: the entry list straight from the requirements.
    task automatic build(input logic [LEN_W-1:0] len, input logic [19:0] t, input logic term);
        exp_q.delete();
        if (len < 255) begin
            exp_q.push_back({t[19:10], 1'b0, t[8], len[7:0]});
        end else begin
            for (int k = 8; k < LEN_W; k++)
                if (len[k]) exp_q.push_back({t[19:10], 1'b1, t[8], 8'(k)});
            if (len[7:0] != 8'd0) exp_q.push_back({t[19:10], 1'b0, t[8], len[7:0]});
        end
        if (term) exp_q.push_back(20'd0);
    endtask

    task automatic run_txn(input logic [LEN_W-1:0] len, input logic [19:0] t,
                           input logic term, input int rdy_pct, input bit inject);
        logic [19:0] hold_data = '0;
        logic [19:0] e;
        bit hold_pending = 0;
        bit injected = 0;
        int guard = 0;
        string tag;
        build(len, t, term);
        @(negedge clk);
        start_i = 1'b1; len_i = len; tmpl_i = t; term_i = term;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9 busy after start", 32'(busy_o), 32'd1);
        while (exp_q.size() > 0 && guard < 2000) begin
            if (injected) start_i = 1'b0;
            if (hold_pending)
                check(ent_valid_o && ent_data_o == hold_data, "R8 hold during stall",
                      32'(ent_data_o), 32'(hold_data));
            check(ent_valid_o == 1'b1, "R9 valid while entries remain", 32'(ent_valid_o), 32'd1);
            ent_ready_i = ($urandom_range(99) < rdy_pct);
            if (inject && !injected && guard == 1) begin
                start_i = 1'b1; len_i = 25'h0000_3FF; tmpl_i = 20'hFFFFF; term_i = 1'b1;
                injected = 1;
            end
            if (ent_ready_i && ent_valid_o) begin
                e = exp_q.pop_front();
                if (term && exp_q.size() == 0) tag = "R7 terminator";
                else if (e[9]) tag = "R2 R3 exponent entry";
                else if (len == 255) tag = "R5 literal 255";
                else if (len < 255) tag = "R1 single literal";
                else tag = "R4 trailing literal";
                if (inject) tag = {tag, " R10"};
                check(ent_data_o == e, tag, 32'(ent_data_o), 32'(e));
                if (!(term && exp_q.size() == 0))
                    check(ent_data_o[19:10] == t[19:10] && ent_data_o[8] == t[8],
                          "R6 template copy", 32'(ent_data_o), 32'(t));
                hold_pending = 0;
            end else begin
                hold_pending = 1;
                hold_data = ent_data_o;
            end
            @(negedge clk);
            guard++;
        end
        start_i = 1'b0;
        ent_ready_i = 1'b0;
        if (guard >= 2000) check(1'b0, "R9 transaction stalled", 32'(guard), 32'd0);
        check(done_o == 1'b1, "R9 done pulse", 32'(done_o), 32'd1);
        check(busy_o == 1'b0 && ent_valid_o == 1'b0, "R9 idle after last entry",
              32'({busy_o, ent_valid_o}), 32'd0);
        @(negedge clk);
        check(done_o == 1'b0, "R9 done lasts one cycle", 32'(done_o), 32'd0);
        if (inject)
            check(busy_o == 1'b0 && ent_valid_o == 1'b0, "R10 no second command",
                  32'({busy_o, ent_valid_o}), 32'd0);
    endtask

    initial begin
        #500us;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!ent_valid_o && !busy_o && !done_o, "R11 reset state",
              32'({ent_valid_o, busy_o, done_o}), 32'd0);

        run_txn(25'd0,        20'hA5B5C, 1'b0, 100, 0);
        run_txn(25'd254,      20'h3C3C3, 1'b0, 60,  0);
        run_txn(25'd255,      20'hFFFFF, 1'b0, 50,  0);
        run_txn(25'd256,      20'h12345, 1'b1, 40,  0);
        run_txn(25'd257,      20'h0F0F0, 1'b0, 100, 0);
        run_txn(25'h000200,   20'h55555, 1'b1, 70,  0);
        run_txn(25'h1000000,  20'hCAFE1, 1'b0, 30,  0);
        run_txn(25'h0FFFFFF,  20'h9ABCD, 1'b1, 50,  1);
        run_txn(25'h0ABCD00,  20'h76543, 1'b0, 80,  1);
        run_txn(25'd100,      20'h00000, 1'b1, 20,  1);
        for (int n = 0; n < 20; n++)
            run_txn(25'($urandom_range(32'h1000000)), 20'($urandom), 1'($urandom), 50, n[0]);

        finished = 1;
        summary();
        $finish;
    end
endmodule